// File: doc/BRIEF.md
# Edge-Started One-Shot Delay Timer

This block produces a single-cycle pulse a programmable number of clock cycles after a rising edge on its start input. The length of the delay is taken from a run-time input at the moment the edge is seen, so a value that changes every run, such as the output of a small pseudo-random generator, yields a random hold time. Once started, the timer ignores the start input until the pulse has been issued.

The timer is single-shot with a lockout. A new delay can only begin after the start input has been seen low again and then rises. If the start input is still high when the pulse is issued, the timer parks until that input drops. A length of zero is treated as a length of one, so a started delay always ends in a pulse.

Top module: `edge_delay_timer`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `time_out` is low and no delay is running.
- R2: A delay starts only at a clock edge where `trigger` is sampled 1 and was sampled 0 at the previous edge. A level that stays high, or stays low, starts nothing.
- R3: If the start edge is edge E0 and the length is L (1 to 2^LEN_W-1), `time_out` is high in the cycle that follows edge E0+L.
- R4: `time_out` is never high in two consecutive cycles.
- R5: A length of 0 behaves exactly like a length of 1.
- R6: The length is captured at the start edge. Changes to `delay_len` after that edge do not move the pulse.
- R7: While a delay is running, falls and rises of `trigger` neither restart it nor add a second pulse.
- R8: If `trigger` is still high in the pulse cycle, no new delay starts until `trigger` has been sampled 0 and then rises again.
- R9: A `trigger` held high through the release of reset does not start a delay.
- R10: If `trigger` is sampled 0 at the edge that ends the pulse cycle, a rise sampled at the very next edge starts a new delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| trigger | input | 1 | Start input; its rising edge starts a delay |
| delay_len | input | LEN_W | Delay length in cycles, captured at the start edge |
| time_out | output | 1 | One-cycle pulse that marks the end of a delay |

## Verification
The pulse cycle and the end of the lockout can fall on the same clock edge: the edge that ends the pulse cycle also samples `trigger` low, so the timer returns to idle at once. The bench provokes this by holding `trigger` high through a short delay, dropping it during the pulse cycle, and raising it again one cycle later. It then judges the result by whether the second pulse arrives exactly at that edge plus the new length. A timer that held its lockout one cycle too long would miss the rise or report the pulse late.

// File: rtl/edt_pkg.sv
package edt_pkg;

    // Default width of the delay length input
    localparam int DEF_LEN_W = 7;

    // Controller states
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_COUNT = 2'd1,
        ST_PULSE = 2'd2,
        ST_HOLD  = 2'd3
    } tmr_state_e;

    // Commands from the controller to the down counter
    typedef struct packed {
        logic load;
        logic dec;
    } cnt_ctl_t;

    // Number of cycles a length field stands for: zero is promoted to one
    function automatic int unsigned eff_len(input int unsigned len);
        return (len == 0) ? 1 : len;
    endfunction

endpackage

// File: rtl/edt_rise_det.sv
module edt_rise_det (
    input  logic clk,
    input  logic rst,
    input  logic trig_in,
    output logic rise,
    output logic level
);
    // Previous sample; reset to 1 so a level held through reset is not an edge
    logic trig_q;

    always_ff @(posedge clk) begin
        if (rst) trig_q <= 1'b1;
        else     trig_q <= trig_in;
    end

    assign rise  = trig_in & ~trig_q;
    assign level = trig_in;

    // R2: a rise needs a low sample in between, so it never repeats back to back
    p_rise_isolated_r2: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise);

endmodule

// File: rtl/edt_down_counter.sv
module edt_down_counter
    import edt_pkg::*;
#(
    parameter int W = DEF_LEN_W
) (
    input  logic         clk,
    input  logic         rst,
    input  cnt_ctl_t     ctl,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)           cnt <= '0;
        else if (ctl.load) cnt <= load_val;
        else if (ctl.dec)  cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);

    // R6: the count only moves under a command; the length input alone cannot change it
    p_count_held_r6: assert property (@(posedge clk) disable iff (rst)
        (!ctl.load && !ctl.dec) |=> $stable(cnt));

endmodule

// File: rtl/edt_ctrl.sv
module edt_ctrl
    import edt_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     rise,
    input  logic     trig_lvl,
    input  logic     cnt_zero,
    output cnt_ctl_t ctl,
    output logic     time_out
);
    tmr_state_e state, state_nx;

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        ctl      = '0;
        unique case (state)
            ST_IDLE: begin
                if (rise) begin
                    ctl.load = 1'b1;
                    state_nx = ST_COUNT;
                end
            end
            ST_COUNT: begin
                if (cnt_zero) state_nx = ST_PULSE;
                else          ctl.dec  = 1'b1;
            end
            ST_PULSE: begin
                state_nx = trig_lvl ? ST_HOLD : ST_IDLE;
            end
            ST_HOLD: begin
                if (!trig_lvl) state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    assign time_out = (state == ST_PULSE);

    // R2: without a rise the timer stays idle
    p_start_on_rise_r2: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && !rise) |=> state == ST_IDLE);

    // R3: a pulse is only ever reached from a running count
    p_pulse_after_count_r3: assert property (@(posedge clk) disable iff (rst)
        time_out |-> $past(state) == ST_COUNT);

    // R4: the pulse lasts a single cycle
    p_single_pulse_r4: assert property (@(posedge clk) disable iff (rst)
        time_out |=> !time_out);

    // R7: a running count goes on or ends in the pulse, whatever the start input does
    p_no_restart_r7: assert property (@(posedge clk) disable iff (rst)
        (state == ST_COUNT) |=> (state == ST_COUNT || state == ST_PULSE));

    // R8: the lockout holds while the start input stays high
    p_lockout_r8: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HOLD && trig_lvl) |=> state == ST_HOLD);

endmodule

// File: rtl/edge_delay_timer.sv
module edge_delay_timer
    import edt_pkg::*;
#(
    parameter int LEN_W = DEF_LEN_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             trigger,
    input  logic [LEN_W-1:0] delay_len,
    output logic             time_out
);
    localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

    logic             rise;
    logic             trig_lvl;
    logic             cnt_zero;
    cnt_ctl_t         ctl;
    logic [LEN_W-1:0] len_eff;
    logic [LEN_W-1:0] load_val;

    // Zero is promoted to one; the counter holds cycles left minus one
    assign len_eff  = (delay_len == '0) ? ONE : delay_len;
    assign load_val = len_eff - ONE;

    edt_rise_det u_rise (
        .clk     (clk),
        .rst     (rst),
        .trig_in (trigger),
        .rise    (rise),
        .level   (trig_lvl)
    );

    edt_down_counter #(.W(LEN_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .ctl      (ctl),
        .load_val (load_val),
        .zero     (cnt_zero)
    );

    edt_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .rise     (rise),
        .trig_lvl (trig_lvl),
        .cnt_zero (cnt_zero),
        .ctl      (ctl),
        .time_out (time_out)
    );

endmodule

// File: tb/sim_edge_delay_timer.sv
`timescale 1ns/1ps
module sim_edge_delay_timer;

    localparam int LW = 7;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          trigger = 1'b0;
    logic [LW-1:0] delay_len = '0;
    logic          time_out;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int    exp_q[$];
    string tag_q[$];
    logic  chk_low = 1'b0;

    always #10 clk = ~clk;   // 50 MHz
    always @(posedge clk) cyc <= cyc + 1;

    edge_delay_timer #(.LEN_W(LW)) u0 (
        .clk       (clk),
        .rst       (rst),
        .trigger   (trigger),
        .delay_len (delay_len),
        .time_out  (time_out)
    );

    function automatic int cycles_for(input int k);
        return (k == 0) ? 1 : k;
    endfunction

    // Driver: raise trigger at a negedge; the edge that samples it is cyc+1
    task automatic start(input int k, input string tag);
        @(negedge clk);
        delay_len = LW'(k);
        trigger   = 1'b1;
        exp_q.push_back(cyc + 1 + cycles_for(k));
        tag_q.push_back(tag);
    endtask

    task automatic drop();
        @(negedge clk);
        trigger = 1'b0;
    endtask

    task automatic drain();
        while (exp_q.size() > 0) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic quiet(input int n, input string tag);
        int bad = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk); #1;
            if (time_out) bad++;
        end
        checks++;
        if (bad != 0) begin
            fails++;
            $display("FAIL %s: time_out=1 in %0d cycles, expected 0", tag, bad);
        end
    endtask

    // Monitor: compares each pulse against the scoreboard
    initial begin
        forever begin
            @(negedge clk); #1;
            if (!rst) begin
                if (chk_low) begin
                    chk_low = 1'b0;
                    checks++;
                    if (time_out) begin
                        fails++;
                        $display("FAIL R4: time_out=1 two cycles in a row, expected 0");
                    end
                end else if (time_out) begin
                    if (exp_q.size() > 0 && exp_q[0] == cyc) begin
                        checks++;
                        void'(exp_q.pop_front());
                        void'(tag_q.pop_front());
                        chk_low = 1'b1;
                    end else begin
                        fails++;
                        $display("FAIL R3: time_out=1 at cycle %0d, expected %0d",
                                 cyc, (exp_q.size() > 0) ? exp_q[0] : -1);
                    end
                end else if (exp_q.size() > 0 && exp_q[0] <= cyc) begin
                    checks++;
                    fails++;
                    $display("FAIL %s: time_out=0 at cycle %0d, expected 1", tag_q[0], exp_q[0]);
                    void'(exp_q.pop_front());
                    void'(tag_q.pop_front());
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        // R1 and R9: reset with trigger held high
        trigger = 1'b1;
        repeat (4) @(negedge clk);
        checks++;
        if (time_out !== 1'b0) begin
            fails++;
            $display("FAIL R1: time_out=%b during reset, expected 0", time_out);
        end
        rst = 1'b0;
        quiet(1, "R1");
        quiet(20, "R9");
        drop();
        repeat (2) @(negedge clk);

        // R2: low level with a moving length starts nothing
        delay_len = 7'd3;
        quiet(10, "R2");

        // R3: several lengths, including the largest
        start(5, "R3");   drop(); drain();
        start(1, "R3");   drop(); drain();
        start(127, "R3"); drop(); drain();
        start(12, "R3");  drain(); drop(); repeat (2) @(negedge clk);

        // R5: zero acts as one
        start(0, "R5"); drop(); drain();

        // R6: length changes after the start edge are ignored
        start(10, "R6");
        @(negedge clk); delay_len = 7'd3;
        @(negedge clk); delay_len = 7'd0;
        trigger = 1'b0;
        drain();

        // R7: trigger toggling during a run
        start(20, "R7");
        for (int i = 0; i < 4; i++) begin
            drop();
            @(negedge clk); trigger = 1'b1;
        end
        drop();
        drain();

        // R8: trigger still high after the pulse
        start(4, "R8");
        drain();
        quiet(10, "R8");
        drop();
        start(6, "R8");
        drop(); drain();

        // R10: trigger drops in the pulse cycle, rises right after
        start(3, "R10");
        while (cyc < exp_q[0]) @(negedge clk);
        trigger = 1'b0;
        start(5, "R10");
        drop(); drain();

        repeat (3) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule